// File: doc/BRIEF.md
# Interrupt Acknowledge and Running-Priority Unit

This block sits on one processor's side of an interrupt controller and runs the acknowledge and completion handshake. Arbitration happens elsewhere: a selection stage presents the most urgent deliverable interrupt on `sel_*` inputs, with its ID, its priority and, for software interrupts, the ID of the processor that raised it. A read strobe on `ack_rd` returns a packed acknowledge word in the same cycle. If an interrupt is being offered, the unit pulses a pending-clear request back to the pending store and marks that interrupt active.

Software ends a handler by writing a completion word. If the named interrupt is active, its active bit clears. If it is not active, nothing changes and an error pulse is raised. The unit records the priority of each interrupt when it is acknowledged. It keeps a running priority, which is the lowest priority value among the interrupts that are active now. It also holds a 3-bit binary-point register.

Top module: `irq_ack_unit`

## Requirements
- R1: The acknowledge word carries the interrupt ID in bits 9:0 and the source processor in bits 12:10. The source field equals `sel_src` only when the ID is below 16 (a software interrupt); for all other IDs it is 0.
- R2: An acknowledge read while `sel_valid` is low returns ID 1023 with source 0. It raises no pending-clear and leaves the active bits unchanged.
- R3: An acknowledge read while `sel_valid` is high pulses `pend_clr` in that cycle, with `pend_clr_id` equal to the offered ID. The offered interrupt's active bit reads 1 from the next cycle on.
- R4: A completion write whose ID field (bits 9:0) names an active interrupt clears that active bit in the next cycle. The source field (bits 12:10) of the completion word has no effect.
- R5: A completion write that names an interrupt that is not active, including an ID of `NUM_INT` or more, changes no active bit. It raises `eoi_err` for exactly the next cycle.
- R6: `run_prio` equals the smallest priority value recorded at acknowledge among the currently active interrupts, or all ones when none is active. It follows a change of the active bits one cycle later.
- R7: After reset, `active` is 0, `run_prio` is all ones, `eoi_err` is 0 and `bpr` equals `BPR_MIN`.
- R8: A write to the binary-point register keeps only bits 2:0 of `bpr_wdata`, and `bpr` shows them from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sel_valid | input | 1 | A deliverable interrupt is offered |
| sel_id | input | 10 | Offered interrupt ID |
| sel_src | input | 3 | Requesting processor of an offered software interrupt |
| sel_prio | input | PRIO_W | Priority of the offered interrupt |
| ack_rd | input | 1 | Acknowledge register read strobe |
| ack_word | output | 13 | Acknowledge result {source, ID} |
| pend_clr | output | 1 | Request to clear the offered interrupt's pending bit |
| pend_clr_id | output | 10 | ID whose pending bit is to clear |
| eoi_wr | input | 1 | Completion register write strobe |
| eoi_word | input | 13 | Completion word {source, ID} |
| eoi_err | output | 1 | Completion named an interrupt that was not active |
| bpr_wr | input | 1 | Binary-point write strobe |
| bpr_wdata | input | 8 | Binary-point write data |
| bpr | output | 3 | Binary-point register |
| active | output | NUM_INT | Active bit per interrupt ID |
| run_prio | output | PRIO_W | Running priority |

## Verification
The bench builds the unit with `NUM_INT` = 24 and `BPR_MIN` = 3. With only 24 IDs, a completion for ID 30 falls outside the table, which exercises the out-of-range error path. The non-default reset value of the binary point shows that the parameter reaches the register. An 8-bit priority lets the bench stack active interrupts of different urgency and then retire them out of order, so the minimum search is exercised as entries leave.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;
  localparam int ID_W    = 10;
  localparam int SRC_W   = 3;
  localparam int WORD_W  = ID_W + SRC_W;
  localparam int SOFT_IDS = 16;
  localparam logic [ID_W-1:0] NONE_ID = 10'd1023;

  function automatic logic [WORD_W-1:0] pack_word(input logic [ID_W-1:0] id,
                                                  input logic [SRC_W-1:0] src);
    return {src, id};
  endfunction

  function automatic logic [ID_W-1:0] word_id(input logic [WORD_W-1:0] w);
    return w[ID_W-1:0];
  endfunction

  function automatic logic [SRC_W-1:0] src_for(input logic [ID_W-1:0] id,
                                               input logic [SRC_W-1:0] src);
    return (int'(id) < SOFT_IDS) ? src : '0;
  endfunction
endpackage

// File: rtl/irq_ack_former.sv
module irq_ack_former
  import irq_ack_pkg::*;
(
  input  logic              sel_valid,
  input  logic [ID_W-1:0]   sel_id,
  input  logic [SRC_W-1:0]  sel_src,
  input  logic              ack_rd,
  output logic [WORD_W-1:0] ack_word,
  output logic              take,
  output logic [ID_W-1:0]   take_id
);
  always_comb begin
    if (sel_valid) ack_word = pack_word(sel_id, src_for(sel_id, sel_src));
    else           ack_word = pack_word(NONE_ID, '0);
    take    = ack_rd && sel_valid;
    take_id = sel_id;
  end
endmodule

// File: rtl/irq_active_tracker.sv
module irq_active_tracker
  import irq_ack_pkg::*;
#(
  parameter int NUM_INT = 32,
  parameter int PRIO_W  = 8
)(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      take,
  input  logic [ID_W-1:0]           take_id,
  input  logic [PRIO_W-1:0]         take_prio,
  input  logic                      eoi_wr,
  input  logic [ID_W-1:0]           eoi_id,
  output logic [NUM_INT-1:0]        active,
  output logic [NUM_INT*PRIO_W-1:0] prio_flat,
  output logic                      eoi_err
);
  localparam int IDX_W = (NUM_INT > 1) ? $clog2(NUM_INT) : 1;

  logic eoi_in_range, eoi_hit;
  assign eoi_in_range = int'(eoi_id) < NUM_INT;
  assign eoi_hit      = eoi_wr && eoi_in_range && active[eoi_id[IDX_W-1:0]];

  for (genvar i = 0; i < NUM_INT; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        active[i]                      <= 1'b0;
        prio_flat[i*PRIO_W +: PRIO_W]  <= '1;
      end else if (take && take_id == ID_W'(i)) begin
        active[i]                      <= 1'b1;
        prio_flat[i*PRIO_W +: PRIO_W]  <= take_prio;
      end else if (eoi_hit && eoi_id == ID_W'(i)) begin
        active[i]                      <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eoi_err <= 1'b0;
    else        eoi_err <= eoi_wr && !eoi_hit;
  end
endmodule

// File: rtl/irq_runprio_calc.sv
module irq_runprio_calc #(
  parameter int NUM_INT = 32,
  parameter int PRIO_W  = 8
)(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_INT-1:0]        active,
  input  logic [NUM_INT*PRIO_W-1:0] prio_flat,
  output logic [PRIO_W-1:0]         run_prio
);
  logic [PRIO_W-1:0] best;

  always_comb begin
    best = '1;
    for (int i = 0; i < NUM_INT; i++)
      if (active[i] && prio_flat[i*PRIO_W +: PRIO_W] < best)
        best = prio_flat[i*PRIO_W +: PRIO_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_prio <= '1;
    else        run_prio <= best;
  end
endmodule

// File: rtl/irq_ack_unit.sv
module irq_ack_unit
  import irq_ack_pkg::*;
#(
  parameter int          NUM_INT = 32,
  parameter int          PRIO_W  = 8,
  parameter logic [2:0]  BPR_MIN = 3'd2
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel_valid,
  input  logic [9:0]         sel_id,
  input  logic [2:0]         sel_src,
  input  logic [PRIO_W-1:0]  sel_prio,
  input  logic               ack_rd,
  output logic [12:0]        ack_word,
  output logic               pend_clr,
  output logic [9:0]         pend_clr_id,
  input  logic               eoi_wr,
  input  logic [12:0]        eoi_word,
  output logic               eoi_err,
  input  logic               bpr_wr,
  input  logic [7:0]         bpr_wdata,
  output logic [2:0]         bpr,
  output logic [NUM_INT-1:0] active,
  output logic [PRIO_W-1:0]  run_prio
);
  logic [NUM_INT*PRIO_W-1:0] prio_flat;

  irq_ack_former u_former (
    .sel_valid (sel_valid),
    .sel_id    (sel_id),
    .sel_src   (sel_src),
    .ack_rd    (ack_rd),
    .ack_word  (ack_word),
    .take      (pend_clr),
    .take_id   (pend_clr_id)
  );

  irq_active_tracker #(.NUM_INT(NUM_INT), .PRIO_W(PRIO_W)) u_tracker (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (pend_clr),
    .take_id   (pend_clr_id),
    .take_prio (sel_prio),
    .eoi_wr    (eoi_wr),
    .eoi_id    (word_id(eoi_word)),
    .active    (active),
    .prio_flat (prio_flat),
    .eoi_err   (eoi_err)
  );

  irq_runprio_calc #(.NUM_INT(NUM_INT), .PRIO_W(PRIO_W)) u_runprio (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (active),
    .prio_flat (prio_flat),
    .run_prio  (run_prio)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bpr <= BPR_MIN;
    else if (bpr_wr) bpr <= bpr_wdata[2:0];
  end
endmodule

// File: rtl/irq_ack_checker.sv
module irq_ack_checker #(
  parameter int NUM_INT = 32,
  parameter int PRIO_W  = 8
)(
  input logic               clk,
  input logic               rst_n,
  input logic               sel_valid,
  input logic [9:0]         sel_id,
  input logic               ack_rd,
  input logic [12:0]        ack_word,
  input logic               pend_clr,
  input logic [9:0]         pend_clr_id,
  input logic               eoi_wr,
  input logic [12:0]        eoi_word,
  input logic               eoi_err,
  input logic               bpr_wr,
  input logic [7:0]         bpr_wdata,
  input logic [2:0]         bpr,
  input logic [NUM_INT-1:0] active,
  input logic [PRIO_W-1:0]  run_prio
);
  localparam int IDX_W = (NUM_INT > 1) ? $clog2(NUM_INT) : 1;

  // R1 / R3: the pending-clear request names the ID carried in the acknowledge word
  assert_clear_matches_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pend_clr |-> (pend_clr_id == ack_word[9:0]));

  // R2: an empty acknowledge reports the spurious ID and asks for no clear
  assert_spurious_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && !sel_valid) |-> (ack_word == 13'd1023 && !pend_clr));

  assert_spurious_keeps_state_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && !sel_valid && !eoi_wr) |=> $stable(active));

  // R3: an accepted interrupt is active on the next cycle
  assert_ack_sets_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_clr && int'(pend_clr_id) < NUM_INT) |=> active[$past(pend_clr_id[IDX_W-1:0])]);

  // R4: completion of an active ID clears it whatever the source field holds
  assert_eoi_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_wr && !pend_clr && eoi_word[12:10] != 3'd0 && int'(eoi_word[9:0]) < NUM_INT
     && active[eoi_word[IDX_W-1:0]]) |=> !active[$past(eoi_word[IDX_W-1:0])]);

  // R5: completion of an inactive ID raises the error flag and keeps the active set
  assert_eoi_error_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_wr && !pend_clr && (int'(eoi_word[9:0]) >= NUM_INT || !active[eoi_word[IDX_W-1:0]]))
    |=> (eoi_err && $stable(active)));

  // R6: with nothing active the running priority is all ones one cycle later
  assert_idle_runprio_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (active == '0) |=> (run_prio == '1));

  // R8: only the low three bits of a binary-point write are kept
  assert_bpr_low_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bpr_wr && bpr_wdata[7:3] != 5'd0) |=> (bpr == $past(bpr_wdata[2:0])));

  assert_bpr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !bpr_wr |=> $stable(bpr));
endmodule

bind irq_ack_unit irq_ack_checker #(.NUM_INT(NUM_INT), .PRIO_W(PRIO_W)) u_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .sel_valid   (sel_valid),
  .sel_id      (sel_id),
  .ack_rd      (ack_rd),
  .ack_word    (ack_word),
  .pend_clr    (pend_clr),
  .pend_clr_id (pend_clr_id),
  .eoi_wr      (eoi_wr),
  .eoi_word    (eoi_word),
  .eoi_err     (eoi_err),
  .bpr_wr      (bpr_wr),
  .bpr_wdata   (bpr_wdata),
  .bpr         (bpr),
  .active      (active),
  .run_prio    (run_prio)
);

// File: tb/test_irq_ack_unit.sv
`timescale 1ns/1ps
module test_irq_ack_unit;
  localparam int NI = 24;
  localparam int PW = 8;
  localparam logic [2:0] BMIN = 3'd3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sel_valid = 0, ack_rd = 0, eoi_wr = 0, bpr_wr = 0;
  logic [9:0] sel_id = '0;
  logic [2:0] sel_src = '0;
  logic [PW-1:0] sel_prio = '0;
  logic [12:0] eoi_word = '0;
  logic [7:0] bpr_wdata = '0;
  logic [12:0] ack_word;
  logic pend_clr, eoi_err;
  logic [9:0] pend_clr_id;
  logic [2:0] bpr;
  logic [NI-1:0] active;
  logic [PW-1:0] run_prio;

  always #5 clk = ~clk;

  irq_ack_unit #(.NUM_INT(NI), .PRIO_W(PW), .BPR_MIN(BMIN)) i_irq_ack_unit (
    .clk(clk), .rst_n(rst_n), .sel_valid(sel_valid), .sel_id(sel_id), .sel_src(sel_src),
    .sel_prio(sel_prio), .ack_rd(ack_rd), .ack_word(ack_word), .pend_clr(pend_clr),
    .pend_clr_id(pend_clr_id), .eoi_wr(eoi_wr), .eoi_word(eoi_word), .eoi_err(eoi_err),
    .bpr_wr(bpr_wr), .bpr_wdata(bpr_wdata), .bpr(bpr), .active(active), .run_prio(run_prio));

  // scoreboard entry: signal selector 0 ack_word,1 active,2 run_prio,3 eoi_err,4 bpr,5 pend_clr,6 pend_clr_id
  typedef struct { int due; string req; int sig; logic [31:0] exp; } item_t;
  item_t sb[$];
  int cyc = 0, n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [NI-1:0] m_act = '0;
  logic [PW-1:0] m_pr [NI];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] observe(int sig);
    case (sig)
      0: return 32'(ack_word);
      1: return 32'(active);
      2: return 32'(run_prio);
      3: return 32'(eoi_err);
      4: return 32'(bpr);
      5: return 32'(pend_clr);
      default: return 32'(pend_clr_id);
    endcase
  endfunction

  always @(negedge clk) begin
    for (int k = sb.size() - 1; k >= 0; k--) begin
      if (sb[k].due == cyc) begin
        n_chk++;
        if (observe(sb[k].sig) !== sb[k].exp) begin
          n_bad++;
          $display("FAIL %s sig%0d actual=%0h expected=%0h", sb[k].req, sb[k].sig,
                   observe(sb[k].sig), sb[k].exp);
        end
        sb.delete(k);
      end
    end
  end

  function automatic logic [PW-1:0] model_min();
    logic [PW-1:0] b = '1;
    for (int i = 0; i < NI; i++) if (m_act[i] && m_pr[i] < b) b = m_pr[i];
    return b;
  endfunction

  function automatic void expect_at(int dly, string req, int sig, logic [31:0] v);
    item_t it;
    it.due = cyc + dly; it.req = req; it.sig = sig; it.exp = v;
    sb.push_back(it);
  endfunction

  // one bus cycle: acknowledge and/or completion and/or binary-point write
  task automatic step(input bit ack, input bit vld, input int id, input int src, input int pr,
                      input bit eoi, input int eid, input int esrc,
                      input bit bw, input int bdata, input string req);
    logic [12:0] w;
    bit err;
    @(posedge clk); #2;
    ack_rd = ack; sel_valid = vld; sel_id = 10'(id); sel_src = 3'(src); sel_prio = PW'(pr);
    eoi_wr = eoi; eoi_word = {3'(esrc), 10'(eid)};
    bpr_wr = bw; bpr_wdata = 8'(bdata);
    w = vld ? {(id < 16) ? 3'(src) : 3'd0, 10'(id)} : 13'd1023;
    if (ack) begin
      expect_at(0, {req, " ack word"}, 0, 32'(w));
      expect_at(0, {req, " pend clr"}, 5, 32'(vld));
      if (vld) expect_at(0, {req, " pend id"}, 6, 32'(id));
    end
    err = 0;
    if (eoi) begin
      err = !(eid < NI && m_act[eid]);
      if (!err) m_act[eid] = 1'b0;
    end
    if (ack && vld) begin m_act[id] = 1'b1; m_pr[id] = PW'(pr); end
    if (eoi) expect_at(1, {req, " eoi err"}, 3, 32'(err));
    expect_at(1, {req, " active"}, 1, 32'(m_act));
    expect_at(2, {req, " run prio"}, 2, 32'(model_min()));
    if (bw) expect_at(1, {req, " bpr"}, 4, 32'(bdata & 7));
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(posedge clk); #2;
      ack_rd = 0; eoi_wr = 0; bpr_wr = 0; sel_valid = 0;
    end
  endtask

  initial begin
    for (int i = 0; i < NI; i++) m_pr[i] = '1;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R7: reset state
    expect_at(0, "R7 reset", 1, 32'd0);
    expect_at(0, "R7 reset", 2, 32'hFF);
    expect_at(0, "R7 reset", 3, 32'd0);
    expect_at(0, "R7 reset", 4, 32'(BMIN));
    // R1 R3: shared interrupt, source field forced to zero
    step(1,1, 20,5,8'h40, 0,0,0, 0,0, "R1 R3 shared ack");
    // R1 R3 R6: software interrupt keeps its source, lower urgency
    step(1,1, 3,5,8'h80, 0,0,0, 0,0, "R1 R3 soft ack");
    idle(1);
    // R6: a more urgent one then a less urgent one
    step(1,1, 15,2,8'h10, 0,0,0, 0,0, "R6 ack urgent");
    step(1,1, 16,6,8'hC0, 0,0,0, 0,0, "R1 R6 ack id16");
    // R2: spurious acknowledge
    step(1,0, 7,4,8'h00, 0,0,0, 0,0, "R2 spurious");
    // R4: complete most urgent with a nonzero source field
    step(0,0, 0,0,0, 1,15,7, 0,0, "R4 R6 eoi urgent");
    step(0,0, 0,0,0, 1,20,3, 0,0, "R4 R6 eoi shared");
    // R5: repeat completion, out of range, never acked
    step(0,0, 0,0,0, 1,20,0, 0,0, "R5 eoi repeat");
    step(0,0, 0,0,0, 1,30,0, 0,0, "R5 eoi out of range");
    step(0,0, 0,0,0, 1,1023,0, 0,0, "R5 eoi spurious id");
    // simultaneous acknowledge and completion of different IDs
    step(1,1, 9,1,8'h20, 1,3,0, 0,0, "R3 R4 R6 ack with eoi");
    step(0,0, 0,0,0, 1,9,0, 0,0, "R4 R6 eoi 9");
    step(0,0, 0,0,0, 1,16,0, 0,0, "R4 R6 last eoi");
    // R8: binary point keeps low bits
    step(0,0, 0,0,0, 0,0,0, 1,8'hFD, "R8 bpr high bits");
    step(0,0, 0,0,0, 0,0,0, 1,8'h01, "R8 bpr low");
    idle(1);
    expect_at(0, "R8 bpr holds", 4, 32'd1);
    expect_at(0, "R6 idle", 2, 32'hFF);
    idle(4);
    if (sb.size() != 0) begin
      n_bad++;
      $display("FAIL scoreboard residue actual=%0d expected=0", sb.size());
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule